// File: doc/BRIEF.md
# ECC Symbol Correction Applier

This block sits behind a Reed-Solomon decoder on a flash page read path. The decoder hands over a short list of corrections. Each one gives a 12-bit symbol position and a 12-bit error pattern. The block XORs each pattern into a byte-wide page RAM that holds 2048 data bytes, with the spare bytes from address 2048 upward. Code symbols are 12 bits wide, so most symbols straddle two bytes with a 4-bit offset. The block computes which bytes a symbol covers and applies the change by read-modify-write through the RAM port.

Corrections arrive on a valid/ready handshake. A last flag closes the page. After the final write of a page the block pulses done. At that point it reports whether the page could be corrected and how many symbols it repaired. Decoding the code itself is done elsewhere.

Top module: `ecc_fix_apply`

## Requirements
- R1: An odd position p (1 to 1373) XORs pattern bits 11..4 into byte 3p/2 (rounded down). It XORs pattern bits 3..0 into bits 7..4 of byte 3p/2+1. Spare byte k sits at linear address 2048+k, so position 1365 touches data byte 2047 and spare byte 0.
- R2: An even nonzero position p (2 to 1374) XORs pattern bits 11..8 into bits 3..0 of byte 3p/2-1. It XORs pattern bits 7..0 into byte 3p/2.
- R3: Position 0 maps to byte 0 alone. If pattern bits 11..8 are all zero, byte 0 is XORed with pattern bits 7..0. Otherwise the page is marked failed and nothing is written.
- R4: A position above 1374 marks the page failed. Once a page has failed, no RAM write happens for the rest of that page. Bytes corrected earlier in the page stay as written.
- R5: At most four corrections are handled per page. Later corrections in the same page are accepted but cause no write and do not affect the page status.
- R6: Every byte update is one read cycle followed by one write cycle to the same address, with a one-cycle read latency. fix_ready_o is low for 4 cycles after accepting a two-byte correction and for 2 cycles after a position-0 correction.
- R7: After the last correction of a page has been accepted and its writes have finished, done_o is high for exactly one cycle. At that point fail_o gives the page status and cnt_o gives the number of corrections applied. cnt_o reads 0 when fail_o is set. Both hold until the next page's first correction is accepted.
- R8: After reset the block is ready, with done_o, fail_o, ram_we_o and cnt_o all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fix_valid_i | input | 1 | Correction offered |
| fix_ready_o | output | 1 | Correction can be taken |
| fix_pos_i | input | 12 | Symbol position |
| fix_pat_i | input | 12 | Error pattern |
| fix_last_i | input | 1 | Final correction of the page |
| ram_addr_o | output | 12 | Page RAM byte address |
| ram_we_o | output | 1 | Page RAM write enable |
| ram_wdata_o | output | 8 | Page RAM write data |
| ram_rdata_i | input | 8 | Page RAM read data, one cycle after the address |
| done_o | output | 1 | Page finished pulse |
| fail_o | output | 1 | Page uncorrectable |
| cnt_o | output | 3 | Corrections applied in the page |

## Verification
The bench models the page as a bit stream in which symbol p covers bits 12p-4 to 12p+7, most significant bit first. It compares the whole RAM after every page against that model. This catches a design that swaps nibbles, drops the 4-bit offset, or loses the carry from data byte 2047 into spare byte 0. Several cases are aimed at specific mistakes:
- Two adjacent symbols that share a byte show whether a design reads the value before a pending write has landed.
- Position 0 with a high nibble set, and positions 1375 and 4095, show whether a design writes bytes it should reject.
- A bad symbol followed by a good one shows whether a design resumes writing after a failure.
- A fifth correction in a page shows whether a design overruns its limit.

Counts of write-enable cycles and of ready-low cycles show whether a design skips the read or holds the port for the wrong number of cycles.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  parameter int unsigned SYM_W  = 12;
  parameter int unsigned ADDR_W = 12;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_WR0, ST_RD1, ST_WR1, ST_DONE
  } fix_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] mask;
  } byte_op_t;
endpackage

// File: rtl/ecc_sym_map.sv
module ecc_sym_map
  import ecc_fix_pkg::*;
#(
  parameter int unsigned MAX_POS = 1374
) (
  input  logic [SYM_W-1:0] pos_i,
  input  logic [SYM_W-1:0] pat_i,
  output logic             bad_o,
  output logic             two_o,
  output byte_op_t         op0_o,
  output byte_op_t         op1_o
);
  localparam int unsigned PROD_W = SYM_W + 2;

  logic [PROD_W-1:0] half3;

  always_comb begin
    half3 = (PROD_W'(pos_i) * PROD_W'(3)) >> 1;
    bad_o = 1'b0;
    two_o = 1'b1;
    op0_o = '0;
    op1_o = '0;
    if (pos_i > SYM_W'(MAX_POS)) begin
      bad_o = 1'b1;
    end else if (pos_i == '0) begin
      // symbol 0 has only 8 data bits
      two_o      = 1'b0;
      bad_o      = |pat_i[11:8];
      op0_o.mask = pat_i[7:0];
    end else if (pos_i[0]) begin
      op0_o.addr = ADDR_W'(half3);
      op0_o.mask = pat_i[11:4];
      op1_o.addr = ADDR_W'(half3 + PROD_W'(1));
      op1_o.mask = {pat_i[3:0], 4'h0};
    end else begin
      op0_o.addr = ADDR_W'(half3 - PROD_W'(1));
      op0_o.mask = {4'h0, pat_i[11:8]};
      op1_o.addr = ADDR_W'(half3);
      op1_o.mask = pat_i[7:0];
    end
  end
endmodule

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
  import ecc_fix_pkg::*;
#(
  parameter int unsigned MAX_FIX = 4,
  parameter int unsigned CNT_W   = $clog2(MAX_FIX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fix_valid_i,
  input  logic              fix_last_i,
  output logic              fix_ready_o,
  input  logic              bad_i,
  input  logic              two_i,
  input  byte_op_t          op0_i,
  input  byte_op_t          op1_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  cnt_o
);
  fix_state_e       st_q, st_d;
  byte_op_t         op0_q, op1_q;
  logic             two_q, last_q, open_q, fail_q;
  logic [CNT_W-1:0] seen_q;

  logic             accept, base_fail, full, apply;
  logic [CNT_W-1:0] base_seen;

  assign fix_ready_o = (st_q == ST_IDLE);
  assign accept      = fix_valid_i && fix_ready_o;

  always_comb begin
    // first correction of a page starts from a clean status
    base_fail = open_q ? fail_q : 1'b0;
    base_seen = open_q ? seen_q : '0;
    full      = (base_seen == CNT_W'(MAX_FIX));
    apply     = !base_fail && !bad_i && !full;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = apply ? ST_RD0 : (fix_last_i ? ST_DONE : ST_IDLE);
      ST_RD0:  st_d = ST_WR0;
      ST_WR0:  st_d = two_q ? ST_RD1 : (last_q ? ST_DONE : ST_IDLE);
      ST_RD1:  st_d = ST_WR1;
      ST_WR1:  st_d = last_q ? ST_DONE : ST_IDLE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op0_q  <= '0;
      op1_q  <= '0;
      two_q  <= 1'b0;
      last_q <= 1'b0;
      open_q <= 1'b0;
      fail_q <= 1'b0;
      seen_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op0_q  <= op0_i;
        op1_q  <= op1_i;
        two_q  <= two_i;
        last_q <= fix_last_i;
        open_q <= !fix_last_i;
        fail_q <= base_fail || (bad_i && !full);
        seen_q <= full ? base_seen : base_seen + CNT_W'(1);
      end
    end
  end

  logic     hi_byte;
  byte_op_t cur_op;

  assign hi_byte     = (st_q == ST_RD1) || (st_q == ST_WR1);
  assign cur_op      = hi_byte ? op1_q : op0_q;
  assign ram_addr_o  = cur_op.addr;
  assign ram_we_o    = (st_q == ST_WR0) || (st_q == ST_WR1);
  assign ram_wdata_o = ram_rdata_i ^ cur_op.mask;
  assign done_o      = (st_q == ST_DONE);
  assign fail_o      = fail_q;
  assign cnt_o       = fail_q ? '0 : seen_q;
endmodule

// File: rtl/ecc_fix_apply.sv
module ecc_fix_apply
  import ecc_fix_pkg::*;
#(
  parameter int unsigned MAX_FIX = 4,
  parameter int unsigned MAX_POS = 1374,
  parameter int unsigned CNT_W   = $clog2(MAX_FIX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fix_valid_i,
  output logic              fix_ready_o,
  input  logic [SYM_W-1:0]  fix_pos_i,
  input  logic [SYM_W-1:0]  fix_pat_i,
  input  logic              fix_last_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic     map_bad, map_two;
  byte_op_t map_op0, map_op1;

  ecc_sym_map #(.MAX_POS(MAX_POS)) i_map (
    .pos_i (fix_pos_i),
    .pat_i (fix_pat_i),
    .bad_o (map_bad),
    .two_o (map_two),
    .op0_o (map_op0),
    .op1_o (map_op1)
  );

  ecc_fix_ctrl #(.MAX_FIX(MAX_FIX), .CNT_W(CNT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fix_valid_i (fix_valid_i),
    .fix_last_i  (fix_last_i),
    .fix_ready_o (fix_ready_o),
    .bad_i       (map_bad),
    .two_i       (map_two),
    .op0_i       (map_op0),
    .op1_i       (map_op1),
    .ram_addr_o  (ram_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_rdata_i (ram_rdata_i),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .cnt_o       (cnt_o)
  );
endmodule

// File: rtl/ecc_fix_chk.sv
module ecc_fix_chk
  import ecc_fix_pkg::*;
#(
  parameter int unsigned MAX_FIX = 4,
  parameter int unsigned CNT_W   = $clog2(MAX_FIX + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fix_ready_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [CNT_W-1:0]  cnt_o
);
  // R6
  rmw_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ($past(!ram_we_o) && $past(ram_addr_o) == ram_addr_o));

  // R6
  busy_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> !fix_ready_o);

  // R4
  no_write_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !ram_we_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!fix_ready_o && !ram_we_o));

  // R7
  fail_zero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (cnt_o == '0));

  // R5
  cnt_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_W'(MAX_FIX));
endmodule

bind ecc_fix_apply ecc_fix_chk #(.MAX_FIX(MAX_FIX), .CNT_W(CNT_W)) i_ecc_fix_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fix_ready_o (fix_ready_o),
  .ram_addr_o  (ram_addr_o),
  .ram_we_o    (ram_we_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .cnt_o       (cnt_o)
);

// File: tb/test_ecc_fix_apply.sv
`timescale 1ns/1ps
module test_ecc_fix_apply;
  localparam int PAGE_BYTES = 2112;
  localparam int NV = 18;

  typedef struct packed {
    logic [11:0] pos;
    logic [11:0] pat;
    logic        last;
    logic        efail;
    logic [2:0]  ecnt;
  } vec_t;

  // efail/ecnt are checked on the last entry of each page
  localparam vec_t VECS [NV] = '{
    '{12'd1,    12'hABC, 1'b0, 1'b0, 3'd0},  // page A: R1 R2, shared byte
    '{12'd2,    12'h123, 1'b0, 1'b0, 3'd0},
    '{12'd1365, 12'hF0F, 1'b1, 1'b0, 3'd3},  // data/spare straddle
    '{12'd0,    12'h0A5, 1'b0, 1'b0, 3'd0},  // page B: R3 legal, spare area
    '{12'd1374, 12'hFFF, 1'b0, 1'b0, 3'd0},
    '{12'd1366, 12'h5A5, 1'b0, 1'b0, 3'd0},
    '{12'd681,  12'h800, 1'b1, 1'b0, 3'd4},
    '{12'd0,    12'h1A5, 1'b1, 1'b1, 3'd0},  // page C: R3 reject
    '{12'd5,    12'h00F, 1'b0, 1'b0, 3'd0},  // page D: R4
    '{12'd1375, 12'h001, 1'b0, 1'b0, 3'd0},
    '{12'd7,    12'hFFF, 1'b1, 1'b1, 3'd0},
    '{12'd10,   12'h001, 1'b0, 1'b0, 3'd0},  // page E: R5
    '{12'd11,   12'h002, 1'b0, 1'b0, 3'd0},
    '{12'd12,   12'h003, 1'b0, 1'b0, 3'd0},
    '{12'd13,   12'h004, 1'b0, 1'b0, 3'd0},
    '{12'd14,   12'h005, 1'b1, 1'b0, 3'd4},
    '{12'd4095, 12'h111, 1'b1, 1'b1, 3'd0},  // page F: R4
    '{12'd1364, 12'h3C3, 1'b1, 1'b0, 3'd1}   // page G: R2 end of data
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fix_valid = 1'b0;
  logic        fix_ready;
  logic [11:0] fix_pos = '0;
  logic [11:0] fix_pat = '0;
  logic        fix_last = 1'b0;
  logic [11:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        done, fail;
  logic [2:0]  cnt;

  logic [7:0]  mem     [PAGE_BYTES];
  logic [7:0]  exp_mem [PAGE_BYTES];

  int  checks = 0;
  int  fails = 0;
  int  wr_cnt = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  ecc_fix_apply i_ecc_fix_apply (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fix_valid_i (fix_valid),
    .fix_ready_o (fix_ready),
    .fix_pos_i   (fix_pos),
    .fix_pat_i   (fix_pat),
    .fix_last_i  (fix_last),
    .ram_addr_o  (ram_addr),
    .ram_we_o    (ram_we),
    .ram_wdata_o (ram_wdata),
    .ram_rdata_i (ram_rdata),
    .done_o      (done),
    .fail_o      (fail),
    .cnt_o       (cnt)
  );

  always @(posedge clk) begin
    ram_rdata <= mem[ram_addr];
    if (ram_we) mem[ram_addr] <= ram_wdata;
  end

  always @(negedge clk) if (ram_we) wr_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // page model state
  bit pfail;
  int pseen;
  int exp_wr;

  // symbol p>0 covers stream bits 12p-4 .. 12p+7, MSB first
  task automatic model_fix(input int pos, input logic [11:0] pat);
    bit bad;
    bad = (pos > 1374) || (pos == 0 && pat > 12'h0FF);
    if (!pfail && pseen < 4) begin
      if (bad) pfail = 1'b1;
      else begin
        for (int k = 0; k < 12; k++) begin
          int s;
          s = 12 * pos - 4 + (11 - k);
          if (s >= 0) exp_mem[s / 8][7 - (s % 8)] ^= pat[k];
        end
        exp_wr += (pos == 0) ? 1 : 2;
      end
    end
    if (pseen < 4) pseen++;
  endtask

  task automatic send(input logic [11:0] p, input logic [11:0] pt, input logic l);
    @(negedge clk);
    fix_valid = 1'b1;
    fix_pos   = p;
    fix_pat   = pt;
    fix_last  = l;
    while (!fix_ready) @(negedge clk);
    @(posedge clk);
    #1 fix_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic page_reset();
    pfail  = 1'b0;
    pseen  = 0;
    exp_wr = 0;
    wr_cnt = 0;
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < PAGE_BYTES; i++) if (mem[i] !== exp_mem[i]) d++;
    return d;
  endfunction

  initial begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      mem[i]     = 8'(i * 37 + 11);
      exp_mem[i] = 8'(i * 37 + 11);
    end
    page_reset();
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(fix_ready === 1'b1 && done === 1'b0 && fail === 1'b0 && ram_we === 1'b0 && cnt === 3'd0,
        "R8 reset outputs", {fix_ready, done, fail, ram_we, cnt}, 7'b1000000);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      vec_t e;
      bit   seen;
      e = VECS[v];
      model_fix(int'(e.pos), e.pat);
      send(e.pos, e.pat, e.last);
      if (e.last) begin
        wait_done(seen);
        chk(seen, "R7 done seen", int'(seen), 1);
        chk(fail === e.efail, "R3 R4 R7 fail status", int'(fail), int'(e.efail));
        chk(cnt === e.ecnt, "R5 R7 applied count", int'(cnt), int'(e.ecnt));
        chk(mem_diff() == 0, "R1 R2 R3 R4 R5 page bytes", mem_diff(), 0);
        chk(wr_cnt == exp_wr, "R4 R5 R6 write cycles", wr_cnt, exp_wr);
        page_reset();
      end
    end

    // R6 handshake occupancy, R7 single-cycle done
    begin
      int  busy;
      bit  seen;
      model_fix(3, 12'h0F0);
      send(12'd3, 12'h0F0, 1'b0);
      busy = 0;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (fix_ready) break;
        busy++;
      end
      chk(busy == 4, "R6 two-byte busy cycles", busy, 4);
      model_fix(0, 12'h011);
      send(12'd0, 12'h011, 1'b0);
      busy = 0;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (fix_ready) break;
        busy++;
      end
      chk(busy == 2, "R6 one-byte busy cycles", busy, 2);
      model_fix(9, 12'h001);
      send(12'd9, 12'h001, 1'b1);
      wait_done(seen);
      chk(seen && cnt === 3'd3 && fail === 1'b0, "R7 done with count", int'(cnt), 3);
      @(negedge clk);
      chk(done === 1'b0, "R7 done single cycle", int'(done), 0);
      chk(cnt === 3'd3, "R7 count held", int'(cnt), 3);
      chk(mem_diff() == 0, "R1 R3 page bytes", mem_diff(), 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule